// File: doc/BRIEF.md
# Up/Down PWM Generator

This block produces one pulse-width-modulated output from a single counter and two compare values. The counter either ramps up from zero to a programmable top value and back down (symmetric mode), or counts down from the top value to zero and wraps (sawtooth mode). Six counter events can each change the output: reaching zero, reaching the top value, and a match on either compare value, told apart by whether the counter is rising or falling. Each event carries a 2-bit action code that leaves the output alone, inverts it, forces it low or forces it high.

A sync input restarts the counter from zero and applies the zero action just as a natural arrival at zero would. A global enable freezes the output and holds the counter at zero. Every event also sets a sticky status bit whatever the interrupt mask says. A one written to a clear bit removes that status bit, even when another event of the generator arrives in the same cycle. New top and compare values are taken only when the counter sits at zero, so a period never mixes old and new settings.

Top module: `updown_pwm_gen`

## Requirements
- R1: In symmetric mode (`mode_updown`=1) with top value N>0 the counter steps by one each cycle through 0,1,...,N,N-1,...,1,0 and repeats, so one period is 2N clocks; the first step after enable goes from 0 to 1.
- R2: In sawtooth mode (`mode_updown`=0) the counter goes N,N-1,...,0 and then reloads N, so one period is N+1 clocks; the first step after enable goes from 0 to N.
- R3: A compare match while the counter rises raises the "up" event of that comparator, and a match while it falls raises the "down" event; in sawtooth mode every match is a "down" event. With top N, compare N-1 (high on up, low on down) gives a 2-clock high pulse per period and compare 1 gives a 2-clock low pulse, never a constant level.
- R4: Action codes are 0 keep, 1 invert, 2 force low, 3 force high; the output register takes the action one clock after the counter holds the event value. With code 2 on zero and code 3 on top, the output is high for N of every 2N clocks in symmetric mode.
- R5: When events coincide, the comparator B action wins over comparator A, any compare action wins over zero and top, and top wins over zero; an event whose code is 0 never overrides another.
- R6: While enabled, `sync` clears the counter to 0 at the next edge, and the zero action is then applied exactly as on a natural arrival at zero.
- R7: While `enable` is low the counter holds 0, no event is raised, the output keeps its value and no status bit is set.
- R8: Status bit positions are 0 zero, 1 top, 2 A rising, 3 A falling, 4 B rising, 5 B falling. An event sets its bit regardless of `int_mask`; `masked_status` is status AND mask and `irq` is its OR.
- R9: A 1 on an `int_clr` bit clears that status bit at the next edge even if another event is raised in the same cycle; if the same event is raised in that cycle the bit stays set.
- R10: Top and compare values applied on the inputs take effect only in a cycle where the counter is at zero (and continuously while disabled); mid-period changes do not alter the current period.
- R11: After reset the output, counter and status are all zero and `irq` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| enable | input | 1 | Global run enable |
| mode_updown | input | 1 | 1 symmetric, 0 sawtooth counting |
| sync | input | 1 | Restart counter from zero |
| load_val | input | CNT_W | Top value (shadowed) |
| cmpa_val | input | CNT_W | Compare A value (shadowed) |
| cmpb_val | input | CNT_W | Compare B value (shadowed) |
| act_zero | input | 2 | Action on zero |
| act_load | input | 2 | Action on top value |
| act_a_up | input | 2 | Action on A match while rising |
| act_a_dn | input | 2 | Action on A match while falling |
| act_b_up | input | 2 | Action on B match while rising |
| act_b_dn | input | 2 | Action on B match while falling |
| int_mask | input | 6 | Interrupt mask per status bit |
| int_clr | input | 6 | Write-one-to-clear pulses per status bit |
| pwm_out | output | 1 | PWM output |
| count_out | output | CNT_W | Current counter value |
| raw_status | output | 6 | Sticky event status |
| masked_status | output | 6 | Status AND mask |
| irq | output | 1 | Any masked status set |

## Verification
The bench drives compare values one step inside the top and one step above zero, where a generator that forgets the counting direction or drops the match at the turnaround would hold the output at a constant level instead of giving 2-clock pulses. It pulses sync in the middle of a high phase; a design that clears the counter without the zero action would leave the output high. It times a status clear onto the exact cycle of a different compare event, where a design that drops a clear on collision would leave the bit set, and onto the same event, where the bit must survive. It also disables the generator with an invert action on zero and changes the top value mid-period, catching a design that toggles while idle or reloads early.

// File: rtl/pwmg_pkg.sv
`timescale 1ns/1ps
// Shared definitions for the PWM generator: action codes, event indices and
// the rule that applies one action to the current output level.
package pwmg_pkg;

    typedef enum logic [1:0] {
        ACT_KEEP = 2'd0,
        ACT_FLIP = 2'd1,
        ACT_LOW  = 2'd2,
        ACT_HIGH = 2'd3
    } act_e;

    localparam int EV_NUM  = 6;
    localparam int EV_ZERO = 0;
    localparam int EV_LOAD = 1;
    localparam int EV_AUP  = 2;
    localparam int EV_ADN  = 3;
    localparam int EV_BUP  = 4;
    localparam int EV_BDN  = 5;
    localparam int N_CMP   = 2;

    // Returns the output level after applying one action code.
    function automatic logic apply_act(input act_e code, input logic cur);
        case (code)
            ACT_FLIP: return ~cur;
            ACT_LOW:  return 1'b0;
            ACT_HIGH: return 1'b1;
            default:  return cur;
        endcase
    endfunction

endpackage

// File: rtl/pwmg_counter.sv
`timescale 1ns/1ps
// Counter with direction flag and shadowed top/compare values.
// Assumes: top value 0 parks the counter at 0; shadows reload only when the
// counter is at zero or the generator is disabled.
module pwmg_counter #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             enable,
    input  logic             mode_updown,
    input  logic             sync,
    input  logic [CNT_W-1:0] load_in,
    input  logic [CNT_W-1:0] cmpa_in,
    input  logic [CNT_W-1:0] cmpb_in,
    output logic [CNT_W-1:0] cnt,
    output logic [CNT_W-1:0] ld_act,
    output logic [CNT_W-1:0] ca_act,
    output logic [CNT_W-1:0] cb_act,
    output logic             dir_up
);
    localparam logic [CNT_W-1:0] ZERO = '0;
    localparam logic [CNT_W-1:0] ONE  = CNT_W'(1);

    logic             at_zero;
    logic [CNT_W-1:0] ld_eff;
    logic [CNT_W-1:0] cnt_nxt;
    logic             dir_nxt;

    assign at_zero = (cnt == ZERO);
    // At zero the incoming top value already governs the next step.
    assign ld_eff  = at_zero ? load_in : ld_act;

    // Next counter value and direction for the selected counting mode.
    always_comb begin
        cnt_nxt = cnt;
        dir_nxt = dir_up;
        if (sync) begin
            cnt_nxt = ZERO;
            dir_nxt = 1'b0;
        end else if (!mode_updown) begin
            dir_nxt = 1'b0;
            cnt_nxt = at_zero ? ld_eff : cnt - ONE;
        end else if (ld_eff == ZERO) begin
            cnt_nxt = ZERO;
            dir_nxt = 1'b0;
        end else if (dir_up) begin
            if (cnt >= ld_eff) begin
                cnt_nxt = cnt - ONE;
                dir_nxt = 1'b0;
            end else begin
                cnt_nxt = cnt + ONE;
            end
        end else if (at_zero) begin
            cnt_nxt = ONE;
            dir_nxt = 1'b1;
        end else begin
            cnt_nxt = cnt - ONE;
        end
    end

    // Counter, direction and shadow registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt    <= ZERO;
            dir_up <= 1'b0;
            ld_act <= ZERO;
            ca_act <= ZERO;
            cb_act <= ZERO;
        end else if (!enable) begin
            cnt    <= ZERO;
            dir_up <= 1'b0;
            ld_act <= load_in;
            ca_act <= cmpa_in;
            cb_act <= cmpb_in;
        end else begin
            cnt    <= cnt_nxt;
            dir_up <= dir_nxt;
            if (at_zero) begin
                ld_act <= load_in;
                ca_act <= cmpa_in;
                cb_act <= cmpb_in;
            end
        end
    end

endmodule

// File: rtl/pwmg_events.sv
`timescale 1ns/1ps
// Decodes the six counter events from the registered count and direction.
// Assumes: all events are suppressed while the generator is disabled.
module pwmg_events
    import pwmg_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic              enable,
    input  logic [CNT_W-1:0]  cnt,
    input  logic              dir_up,
    input  logic [CNT_W-1:0]  ld_act,
    input  logic [CNT_W-1:0]  ca_act,
    input  logic [CNT_W-1:0]  cb_act,
    output logic [EV_NUM-1:0] ev
);
    logic [CNT_W-1:0] cmp_v [N_CMP];

    assign cmp_v[0] = ca_act;
    assign cmp_v[1] = cb_act;

    // Zero and top events.
    assign ev[EV_ZERO] = enable && (cnt == '0);
    assign ev[EV_LOAD] = enable && (cnt == ld_act);

    // Per comparator: match split by the direction of the last step.
    for (genvar g = 0; g < N_CMP; g++) begin : g_cmp
        logic hit;
        assign hit              = enable && (cnt == cmp_v[g]);
        assign ev[EV_AUP + 2*g] = hit && dir_up;
        assign ev[EV_ADN + 2*g] = hit && !dir_up;
    end

endmodule

// File: rtl/pwmg_action.sv
`timescale 1ns/1ps
// Output register: selects the winning action among coinciding events and
// applies it. Higher event index wins; code 0 never overrides.
module pwmg_action
    import pwmg_pkg::*;
(
    input  logic                clk,
    input  logic                rst_n,
    input  logic [EV_NUM-1:0]   ev,
    input  logic [2*EV_NUM-1:0] act_vec,
    output logic                pwm_out
);
    act_e chosen;

    // Priority pick: later (higher) event index overrides earlier ones.
    always_comb begin
        chosen = ACT_KEEP;
        for (int i = 0; i < EV_NUM; i++) begin
            if (ev[i] && (act_e'(act_vec[2*i +: 2]) != ACT_KEEP)) begin
                chosen = act_e'(act_vec[2*i +: 2]);
            end
        end
    end

    // Output level register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pwm_out <= 1'b0;
        end else begin
            pwm_out <= apply_act(chosen, pwm_out);
        end
    end

endmodule

// File: rtl/pwmg_irq.sv
`timescale 1ns/1ps
// Sticky event status with per-bit write-one-to-clear and mask.
// Assumes: a new event on a bit outranks a clear of that same bit.
module pwmg_irq
    import pwmg_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [EV_NUM-1:0] ev,
    input  logic [EV_NUM-1:0] clr,
    input  logic [EV_NUM-1:0] mask,
    output logic [EV_NUM-1:0] raw,
    output logic [EV_NUM-1:0] masked,
    output logic              irq
);
    // Each bit is handled alone, so clears never interact across bits.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            raw <= '0;
        end else begin
            raw <= (raw & ~clr) | ev;
        end
    end

    assign masked = raw & mask;
    assign irq    = |masked;

endmodule

// File: rtl/updown_pwm_gen.sv
`timescale 1ns/1ps
// Top of the PWM generator: counter, event decode, output action and status.
// Assumes: configuration inputs are held steady by the surrounding logic.
module updown_pwm_gen
    import pwmg_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             enable,
    input  logic             mode_updown,
    input  logic             sync,
    input  logic [CNT_W-1:0] load_val,
    input  logic [CNT_W-1:0] cmpa_val,
    input  logic [CNT_W-1:0] cmpb_val,
    input  logic [1:0]       act_zero,
    input  logic [1:0]       act_load,
    input  logic [1:0]       act_a_up,
    input  logic [1:0]       act_a_dn,
    input  logic [1:0]       act_b_up,
    input  logic [1:0]       act_b_dn,
    input  logic [5:0]       int_mask,
    input  logic [5:0]       int_clr,
    output logic             pwm_out,
    output logic [CNT_W-1:0] count_out,
    output logic [5:0]       raw_status,
    output logic [5:0]       masked_status,
    output logic             irq
);
    logic [CNT_W-1:0]    cnt;
    logic [CNT_W-1:0]    ld_act;
    logic [CNT_W-1:0]    ca_act;
    logic [CNT_W-1:0]    cb_act;
    logic                dir_up;
    logic [EV_NUM-1:0]   ev_vec;
    logic [2*EV_NUM-1:0] act_vec;

    // Action codes packed in event-index order.
    assign act_vec = {act_b_dn, act_b_up, act_a_dn, act_a_up, act_load, act_zero};

    pwmg_counter #(.CNT_W(CNT_W)) u_cnt (
        .clk         (clk),
        .rst_n       (rst_n),
        .enable      (enable),
        .mode_updown (mode_updown),
        .sync        (sync),
        .load_in     (load_val),
        .cmpa_in     (cmpa_val),
        .cmpb_in     (cmpb_val),
        .cnt         (cnt),
        .ld_act      (ld_act),
        .ca_act      (ca_act),
        .cb_act      (cb_act),
        .dir_up      (dir_up)
    );

    pwmg_events #(.CNT_W(CNT_W)) u_ev (
        .enable (enable),
        .cnt    (cnt),
        .dir_up (dir_up),
        .ld_act (ld_act),
        .ca_act (ca_act),
        .cb_act (cb_act),
        .ev     (ev_vec)
    );

    pwmg_action u_act (
        .clk     (clk),
        .rst_n   (rst_n),
        .ev      (ev_vec),
        .act_vec (act_vec),
        .pwm_out (pwm_out)
    );

    pwmg_irq u_irq (
        .clk    (clk),
        .rst_n  (rst_n),
        .ev     (ev_vec),
        .clr    (int_clr),
        .mask   (int_mask),
        .raw    (raw_status),
        .masked (masked_status),
        .irq    (irq)
    );

    assign count_out = cnt;

endmodule

// File: rtl/pwmg_checker.sv
`timescale 1ns/1ps
// Property checker for the PWM generator, bound into the top module.
module pwmg_checker #(
    parameter int CNT_W = 16
) (
    input logic             clk,
    input logic             rst_n,
    input logic             enable,
    input logic             sync,
    input logic             mode_updown,
    input logic [CNT_W-1:0] load_in,
    input logic [5:0]       int_clr,
    input logic [1:0]       act_zero,
    input logic [CNT_W-1:0] count_out,
    input logic             pwm_out,
    input logic [5:0]       raw_status,
    input logic [5:0]       ev,
    input logic [CNT_W-1:0] ld_act
);
    localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

    // R1: symmetric counting moves by exactly one per cycle.
    a_r1_unit_step: assert property (@(posedge clk) disable iff (!rst_n)
        (enable && !sync && mode_updown && ld_act != '0 && load_in != '0)
        |=> (count_out == $past(count_out) + ONE) || (count_out == $past(count_out) - ONE));

    // R4: a lone zero event with force-low drives the output low.
    a_r4_zero_low: assert property (@(posedge clk) disable iff (!rst_n)
        (ev[1:0] == 2'b01 && ev[5:2] == 4'b0000 && act_zero == 2'd2) |=> !pwm_out);

    // R6: sync clears the counter at the next edge.
    a_r6_sync_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (enable && sync) |=> count_out == '0);

    // R7: output frozen while disabled.
    a_r7_out_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !enable |=> $stable(pwm_out));

    // R7: counter parked at zero while disabled.
    a_r7_cnt_clear: assert property (@(posedge clk) disable iff (!rst_n)
        !enable |=> count_out == '0);

    for (genvar i = 0; i < 6; i++) begin : g_bit
        // R8: every event sets its status bit.
        a_r8_event_sets: assert property (@(posedge clk) disable iff (!rst_n)
            ev[i] |=> raw_status[i]);
        // R9: a clear without a same-bit event always succeeds.
        a_r9_clear_works: assert property (@(posedge clk) disable iff (!rst_n)
            (int_clr[i] && !ev[i]) |=> !raw_status[i]);
    end

endmodule

bind updown_pwm_gen pwmg_checker #(.CNT_W(CNT_W)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .enable      (enable),
    .sync        (sync),
    .mode_updown (mode_updown),
    .load_in     (load_val),
    .int_clr     (int_clr),
    .act_zero    (act_zero),
    .count_out   (count_out),
    .pwm_out     (pwm_out),
    .raw_status  (raw_status),
    .ev          (ev_vec),
    .ld_act      (ld_act)
);

// File: tb/tb_updown_pwm_gen.sv
`timescale 1ns/1ps
module tb_updown_pwm_gen;
    localparam int CW = 16;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          enable = 1'b0;
    logic          mode_updown = 1'b1;
    logic          sync = 1'b0;
    logic [CW-1:0] load_val = '0;
    logic [CW-1:0] cmpa_val = '0;
    logic [CW-1:0] cmpb_val = '0;
    logic [1:0]    act_zero = 2'd0, act_load = 2'd0;
    logic [1:0]    act_a_up = 2'd0, act_a_dn = 2'd0;
    logic [1:0]    act_b_up = 2'd0, act_b_dn = 2'd0;
    logic [5:0]    int_mask = '0;
    logic [5:0]    int_clr = '0;
    logic          pwm_out;
    logic [CW-1:0] count_out;
    logic [5:0]    raw_status, masked_status;
    logic          irq;

    int  n_chk = 0;
    int  n_err = 0;
    bit  done  = 0;

    typedef struct { string tag; int exp; } item_t;
    item_t sbq[$];

    always #10 clk = ~clk;

    updown_pwm_gen #(.CNT_W(CW)) dut (
        .clk(clk), .rst_n(rst_n), .enable(enable), .mode_updown(mode_updown),
        .sync(sync), .load_val(load_val), .cmpa_val(cmpa_val), .cmpb_val(cmpb_val),
        .act_zero(act_zero), .act_load(act_load), .act_a_up(act_a_up),
        .act_a_dn(act_a_dn), .act_b_up(act_b_up), .act_b_dn(act_b_dn),
        .int_mask(int_mask), .int_clr(int_clr), .pwm_out(pwm_out),
        .count_out(count_out), .raw_status(raw_status),
        .masked_status(masked_status), .irq(irq)
    );

    // Driver side: queue an expected value.
    task automatic sb_expect(input string tag, input int exp);
        item_t it;
        it.tag = tag;
        it.exp = exp;
        sbq.push_back(it);
    endtask

    // Monitor side: pop the oldest expectation and compare.
    task automatic sb_observe(input int act);
        item_t it;
        n_chk++;
        if (sbq.size() == 0) begin
            n_err++;
            $display("FAIL scoreboard empty: actual %0d expected none", act);
        end else begin
            it = sbq.pop_front();
            if (act != it.exp) begin
                n_err++;
                $display("FAIL %s: actual %0d expected %0d", it.tag, act, it.exp);
            end
        end
    endtask

    task automatic check(input string tag, input int act, input int exp);
        sb_expect(tag, exp);
        sb_observe(act);
    endtask

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic set_acts(input logic [1:0] z, input logic [1:0] l, input logic [1:0] au,
                            input logic [1:0] ad, input logic [1:0] bu, input logic [1:0] bd);
        act_zero = z; act_load = l; act_a_up = au; act_a_dn = ad; act_b_up = bu; act_b_dn = bd;
    endtask

    // Disable, load a new setup, then enable; returns one cycle after enable.
    task automatic restart(input logic md, input int ld, input int ca, input int cb);
        enable = 1'b0;
        mode_updown = md;
        load_val = CW'(ld);
        cmpa_val = CW'(ca);
        cmpb_val = CW'(cb);
        tick(1);
        enable = 1'b1;
        tick(1);
    endtask

    // Samples n cycles: cycles at level lvl, longest run of lvl, level changes.
    task automatic measure(input int n, input logic lvl, output int at_lvl,
                           output int max_run, output int flips);
        logic prev;
        int   run;
        prev = pwm_out; at_lvl = 0; max_run = 0; flips = 0; run = 0;
        for (int i = 0; i < n; i++) begin
            tick(1);
            if (pwm_out != prev) flips++;
            prev = pwm_out;
            if (pwm_out == lvl) begin
                at_lvl++; run++;
                if (run > max_run) max_run = run;
            end else begin
                run = 0;
            end
        end
    endtask

    task automatic wait_count(input int v);
        for (int g = 0; g < 400 && count_out != CW'(v); g++) tick(1);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_chk++; n_err++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
            $finish;
        end
    end

    initial begin
        int a, r, f, mx, saved;

        // R11: reset state
        tick(3);
        check("R11 pwm_out", int'(pwm_out), 0);
        check("R11 count", int'(count_out), 0);
        check("R11 status", int'(raw_status), 0);
        check("R11 irq", int'(irq), 0);
        rst_n = 1'b1;
        tick(1);

        // R1: symmetric triangle, N=5, period 10
        set_acts(0, 0, 0, 0, 0, 0);
        for (int k = 1; k <= 12; k++) begin
            int p;
            p = k % 10;
            sb_expect($sformatf("R1 count k=%0d", k), (p <= 5) ? p : 10 - p);
        end
        restart(1'b1, 5, 0, 0);
        for (int k = 1; k <= 12; k++) begin
            sb_observe(int'(count_out));
            if (k < 12) tick(1);
        end

        // R2: sawtooth, N=4, period 5
        for (int k = 1; k <= 11; k++) sb_expect($sformatf("R2 count k=%0d", k), 4 - ((k - 1) % 5));
        restart(1'b0, 4, 0, 0);
        for (int k = 1; k <= 11; k++) begin
            sb_observe(int'(count_out));
            if (k < 11) tick(1);
        end

        // R3: compare at N-1 gives 2-clock high pulses
        set_acts(0, 0, 2'd3, 2'd2, 0, 0);
        restart(1'b1, 99, 98, 500);
        measure(396, 1'b1, a, r, f);
        check("R3 high cycles cmp=N-1", a, 4);
        check("R3 high run cmp=N-1", r, 2);
        // R3: compare at 1 gives 2-clock low pulses
        restart(1'b1, 99, 1, 500);
        measure(396, 1'b0, a, r, f);
        check("R3 low cycles cmp=1", a, 4);
        check("R3 low run cmp=1", r, 2);

        // R4: force low on zero, force high on top, N=8
        set_acts(2'd2, 2'd3, 0, 0, 0, 0);
        restart(1'b1, 8, 0, 0);
        tick(7);
        check("R4 before top k=8", int'(pwm_out), 0);
        tick(1);
        check("R4 after top k=9", int'(pwm_out), 1);
        measure(24, 1'b1, a, r, f);
        check("R4 high cycles k=10..33", a, 15);
        check("R4 high run", r, 8);

        // R5: compare A force-low wins over top force-high
        set_acts(0, 2'd3, 2'd2, 0, 0, 0);
        restart(1'b1, 8, 8, 500);
        measure(32, 1'b1, a, r, f);
        check("R5 A over top highs", a, 0);
        // R5: B force-low wins over A force-high
        set_acts(0, 0, 2'd3, 0, 2'd2, 0);
        restart(1'b1, 8, 3, 3);
        measure(32, 1'b1, a, r, f);
        check("R5 B over A highs", a, 0);

        // R4: invert on zero in sawtooth mode, N=4
        set_acts(2'd1, 0, 0, 0, 0, 0);
        restart(1'b0, 4, 500, 500);
        measure(20, 1'b1, a, r, f);
        check("R4 invert flips", f, 4);

        // R6: sync mid high phase applies the zero action
        set_acts(2'd2, 2'd3, 0, 0, 0, 0);
        restart(1'b1, 50, 500, 500);
        tick(59);
        check("R6 high before sync", int'(pwm_out), 1);
        sync = 1'b1;
        tick(1);
        sync = 1'b0;
        check("R6 count cleared", int'(count_out), 0);
        check("R6 out one cycle after sync", int'(pwm_out), 1);
        tick(1);
        check("R6 zero action applied", int'(pwm_out), 0);

        // R7: disabled generator ignores zero-invert and raises nothing
        set_acts(2'd1, 0, 0, 0, 0, 0);
        restart(1'b1, 8, 500, 500);
        tick(5);
        enable = 1'b0;
        saved = int'(pwm_out);
        tick(1);
        int_clr = 6'h3f;
        tick(1);
        int_clr = '0;
        tick(20);
        check("R7 output held", int'(pwm_out), saved);
        check("R7 count parked", int'(count_out), 0);
        check("R7 no status", int'(raw_status), 0);

        // R8: status set with mask clear; mask gates irq
        set_acts(0, 0, 0, 0, 0, 0);
        int_mask = '0;
        restart(1'b0, 4, 2, 500);
        tick(5);
        check("R8 raw zero/top/A-falling", int'(raw_status), 6'b001011);
        check("R8 masked with mask 0", int'(masked_status), 0);
        check("R8 irq with mask 0", int'(irq), 0);
        int_mask = 6'b000001;
        #1;
        check("R8 masked bit0", int'(masked_status), 1);
        check("R8 irq with bit0", int'(irq), 1);

        // R9: clear bit0 in the cycle A-falling fires
        wait_count(2);
        int_clr = 6'b000001;
        tick(1);
        int_clr = '0;
        check("R9 bit0 cleared on collision", int'(raw_status[0]), 0);
        check("R9 bit3 set", int'(raw_status[3]), 1);
        // R9: clear of bit3 in the cycle bit3 fires keeps it set
        wait_count(2);
        int_clr = 6'b001000;
        tick(1);
        int_clr = '0;
        check("R9 same-bit event wins", int'(raw_status[3]), 1);
        wait_count(4);
        int_clr = 6'b001000;
        tick(1);
        int_clr = '0;
        check("R9 plain clear", int'(raw_status[3]), 0);

        // R10: top value change mid-period waits for zero
        restart(1'b1, 10, 500, 500);
        tick(2);
        load_val = CW'(6);
        mx = 0;
        for (int k = 4; k <= 20; k++) begin
            tick(1);
            if (int'(count_out) > mx) mx = int'(count_out);
        end
        check("R10 old peak kept", mx, 10);
        mx = 0;
        for (int k = 21; k <= 32; k++) begin
            tick(1);
            if (int'(count_out) > mx) mx = int'(count_out);
        end
        check("R10 new peak", mx, 6);

        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end

endmodule